// File: doc/BRIEF.md
# Genlock Raster Resynchroniser

This block produces a video raster from a horizontal and a vertical counter that advance once per character clock, and locks that raster to an external vertical sync reference. The reference is brought into the clock domain through a two-flop synchroniser. A falling edge on it starts a countdown of a programmable number of scan lines. That countdown is followed by a further programmable number of character clocks. When both have run out, the vertical counter returns to zero and the interlace field flag is preset.

A mode input picks one of two resync behaviours. In the first, the horizontal counter also realigns, loading a programmable adjustment value. In the second, only the vertical counter is touched and the horizontal counter runs on. When no reference is present, or genlocking is switched off, the counters free-run and wrap at totals that are supplied as inputs. The block drives sync pulses at the start of each line and each frame, and it has separate output-enable signals for tri-stating each sync pin.

Top module: `genlock_resync`

## Requirements
- R1: While `gl_en_i` is 0, falling edges on `ext_vsync_i` have no effect and the counters keep free-running.
- R2: A falling edge on `ext_vsync_i` first becomes visible at a clock edge counted as edge 0. With genlocking enabled, the resync then takes effect at edge 3 + D*(H+1) + C. Here D is `line_dly_i`, H is `h_total_i` and C is `char_dly_i`. One cycle earlier, the counters still follow their free-running values.
- R3: With genlocking enabled and `line_dly_i` equal to 0, `dly_err_o` is 1 and a falling edge causes no resync. Otherwise `dly_err_o` is 0.
- R4: With `vonly_i` at 0, a resync sets `v_cnt_o` to 0 and loads `h_cnt_o` with `hs_adj_i`. `hs_adj_i` must be no greater than `h_total_i`.
- R5: With `vonly_i` at 1, a resync sets `v_cnt_o` to 0 and leaves the horizontal counter advancing without interruption.
- R6: A resync sets `field_even_o` to `even_start_i`, where 0 means odd and 1 means even. The flag inverts each time the vertical counter wraps.
- R7: `hsync_oe_o` is the inverse of `hs_tri_i`, and `vsync_oe_o` is the inverse of `vs_tri_i`.
- R8: A new falling edge that arrives while a countdown is running restarts the countdown from that new edge. The earlier edge then produces no resync.
- R9: Without a resync, `h_cnt_o` counts from 0 to `h_total_i` and then returns to 0. On that return `v_cnt_o` advances, and `v_cnt_o` returns to 0 after reaching `v_total_i`. Reset clears both counters and `field_even_o`.
- R10: `hsync_o` is 1 exactly when `h_cnt_o` is below `hs_width_i`. `vsync_o` is 1 exactly when `v_cnt_o` is below `vs_width_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_vsync_i | input | 1 | External vertical sync reference, asynchronous |
| gl_en_i | input | 1 | Genlock enable |
| line_dly_i | input | DW (8) | Scan lines from a reference edge to the resync |
| char_dly_i | input | AW (4) | Extra character clocks after the line countdown |
| hs_adj_i | input | AW (4) | Horizontal load value on a full resync |
| vonly_i | input | 1 | 1: resync the vertical counter only |
| even_start_i | input | 1 | Field after a resync: 0 odd, 1 even |
| hs_tri_i | input | 1 | Tri-state request for the horizontal sync pin |
| vs_tri_i | input | 1 | Tri-state request for the vertical sync pin |
| h_total_i | input | HW (11) | Last horizontal count of a line |
| v_total_i | input | VW (11) | Last vertical count of a frame |
| hs_width_i | input | HW (11) | Horizontal sync width in character clocks |
| vs_width_i | input | VW (11) | Vertical sync width in lines |
| h_cnt_o | output | HW (11) | Horizontal counter |
| v_cnt_o | output | VW (11) | Vertical counter |
| field_even_o | output | 1 | Field parity, 1 for an even field |
| hsync_o | output | 1 | Horizontal sync, active high |
| hsync_oe_o | output | 1 | Output enable for the horizontal sync pin |
| vsync_o | output | 1 | Vertical sync, active high |
| vsync_oe_o | output | 1 | Output enable for the vertical sync pin |
| dly_err_o | output | 1 | Illegal zero line delay while genlocking |

## Verification
The hardest case to reach from the ports is the restart of a countdown that is already running. A second reference edge has to land after the first edge has passed the synchroniser but before its resync fires. The stimulus drops the reference, raises it again a few cycles later, and drops it a second time ten cycles after the first drop. It then checks the cycle where the first edge would have fired, expecting free-running counts there, and the cycle where the second edge fires. A free-running model of the raster, rebased at every expected resync, supplies the expected counter values at every checked cycle. This lets the resync timing be checked exactly, including the cycle just before it fires.

// File: rtl/genlock_pkg.sv
package genlock_pkg;
    typedef enum logic [1:0] {
        GL_IDLE  = 2'd0,
        GL_LINES = 2'd1,
        GL_CHARS = 2'd2
    } gl_phase_e;
endpackage

// File: rtl/gl_vsync_sync.sv
module gl_vsync_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic fall_o
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d.s1 = async_i;
        sy_d.s2 = sy_q.s1;
        sy_d.s3 = sy_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy_q <= '1;
        else        sy_q <= sy_d;
    end

    // falling edge seen on the synchronised copy
    assign fall_o = sy_q.s3 & ~sy_q.s2;
endmodule

// File: rtl/gl_resync_seq.sv
module gl_resync_seq
    import genlock_pkg::*;
#(
    parameter int HW = 11,
    parameter int DW = 8,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fall_i,
    input  logic          en_i,
    input  logic [DW-1:0] line_dly_i,
    input  logic [AW-1:0] char_dly_i,
    input  logic [HW-1:0] h_total_i,
    output logic          fire_o,
    output logic          armed_o
);
    typedef struct packed {
        gl_phase_e     phase;
        logic [HW-1:0] tmr;
        logic [DW-1:0] lines;
        logic [AW-1:0] cc;
    } seq_t;

    seq_t st_d, st_q;
    logic arm;

    always_comb begin
        st_d   = st_q;
        fire_o = 1'b0;
        arm    = fall_i && en_i && (line_dly_i != '0);
        if (!en_i) begin
            st_d.phase = GL_IDLE;
        end else if (arm) begin
            st_d.phase = GL_LINES;
            st_d.tmr   = '0;
            st_d.lines = line_dly_i;
        end else begin
            case (st_q.phase)
                GL_LINES: begin
                    if (st_q.tmr == h_total_i) begin
                        st_d.tmr = '0;
                        if (st_q.lines == DW'(1)) begin
                            st_d.phase = GL_CHARS;
                            st_d.cc    = char_dly_i;
                        end else begin
                            st_d.lines = st_q.lines - DW'(1);
                        end
                    end else begin
                        st_d.tmr = st_q.tmr + HW'(1);
                    end
                end
                GL_CHARS: begin
                    if (st_q.cc == '0) begin
                        fire_o     = 1'b1;
                        st_d.phase = GL_IDLE;
                    end else begin
                        st_d.cc = st_q.cc - AW'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{phase: GL_IDLE, tmr: '0, lines: '0, cc: '0};
        else        st_q <= st_d;
    end

    assign armed_o = (st_q.phase != GL_IDLE);
endmodule

// File: rtl/gl_raster.sv
module gl_raster #(
    parameter int HW = 11,
    parameter int VW = 11,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [HW-1:0] h_total_i,
    input  logic [VW-1:0] v_total_i,
    input  logic          fire_i,
    input  logic          vonly_i,
    input  logic          even_start_i,
    input  logic [AW-1:0] hs_adj_i,
    output logic [HW-1:0] h_o,
    output logic [VW-1:0] v_o,
    output logic          even_o
);
    typedef struct packed {
        logic [HW-1:0] h;
        logic [VW-1:0] v;
        logic          even;
    } ras_t;

    ras_t rs_d, rs_q;
    logic line_end, frame_end;

    always_comb begin
        line_end  = (rs_q.h == h_total_i);
        frame_end = line_end && (rs_q.v == v_total_i);
        rs_d      = rs_q;
        rs_d.h    = line_end ? '0 : rs_q.h + HW'(1);
        if (line_end) rs_d.v = frame_end ? '0 : rs_q.v + VW'(1);
        if (frame_end) rs_d.even = ~rs_q.even;
        if (fire_i) begin
            rs_d.v    = '0;
            rs_d.even = even_start_i;
            if (!vonly_i) rs_d.h = HW'(hs_adj_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rs_q <= '0;
        else        rs_q <= rs_d;
    end

    assign h_o    = rs_q.h;
    assign v_o    = rs_q.v;
    assign even_o = rs_q.even;
endmodule

// File: rtl/genlock_resync.sv
module genlock_resync #(
    parameter int HW = 11,
    parameter int VW = 11,
    parameter int DW = 8,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ext_vsync_i,
    input  logic          gl_en_i,
    input  logic [DW-1:0] line_dly_i,
    input  logic [AW-1:0] char_dly_i,
    input  logic [AW-1:0] hs_adj_i,
    input  logic          vonly_i,
    input  logic          even_start_i,
    input  logic          hs_tri_i,
    input  logic          vs_tri_i,
    input  logic [HW-1:0] h_total_i,
    input  logic [VW-1:0] v_total_i,
    input  logic [HW-1:0] hs_width_i,
    input  logic [VW-1:0] vs_width_i,
    output logic [HW-1:0] h_cnt_o,
    output logic [VW-1:0] v_cnt_o,
    output logic          field_even_o,
    output logic          hsync_o,
    output logic          hsync_oe_o,
    output logic          vsync_o,
    output logic          vsync_oe_o,
    output logic          dly_err_o
);
    logic fall, fire, armed;

    gl_vsync_sync u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (ext_vsync_i),
        .fall_o  (fall)
    );

    gl_resync_seq #(.HW(HW), .DW(DW), .AW(AW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .fall_i     (fall),
        .en_i       (gl_en_i),
        .line_dly_i (line_dly_i),
        .char_dly_i (char_dly_i),
        .h_total_i  (h_total_i),
        .fire_o     (fire),
        .armed_o    (armed)
    );

    gl_raster #(.HW(HW), .VW(VW), .AW(AW)) u_ras (
        .clk          (clk),
        .rst_n        (rst_n),
        .h_total_i    (h_total_i),
        .v_total_i    (v_total_i),
        .fire_i       (fire),
        .vonly_i      (vonly_i),
        .even_start_i (even_start_i),
        .hs_adj_i     (hs_adj_i),
        .h_o          (h_cnt_o),
        .v_o          (v_cnt_o),
        .even_o       (field_even_o)
    );

    assign hsync_o    = (h_cnt_o < hs_width_i);
    assign vsync_o    = (v_cnt_o < vs_width_i);
    assign hsync_oe_o = ~hs_tri_i;
    assign vsync_oe_o = ~vs_tri_i;
    assign dly_err_o  = gl_en_i && (line_dly_i == '0);
endmodule

// File: rtl/genlock_resync_chk.sv
module genlock_resync_chk #(
    parameter int HW = 11,
    parameter int VW = 11,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          gl_en,
    input logic [DW-1:0] line_dly,
    input logic          armed,
    input logic [HW-1:0] h,
    input logic [VW-1:0] v,
    input logic [HW-1:0] h_total,
    input logic [VW-1:0] v_total,
    input logic          field_even
);
    // R1: with genlock off no countdown may be running
    a_r1_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !gl_en |=> !armed);

    // R3: a zero line delay never starts a countdown
    a_r3_zero_no_arm: assert property (@(posedge clk) disable iff (!rst_n)
        (gl_en && line_dly == '0 && !armed) |=> !armed);

    // R9: line end returns the horizontal counter to zero
    a_r9_h_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (h == h_total && !armed) |=> h == '0);

    // R9: vertical counter advances at each line end inside the frame
    a_r9_v_step: assert property (@(posedge clk) disable iff (!rst_n)
        (h == h_total && v != v_total && !armed) |=> v == $past(v) + VW'(1));

    // R6: field flag inverts at frame end
    a_r6_field_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (h == h_total && v == v_total && !armed) |=> (v == '0 && field_even != $past(field_even)));
endmodule

bind genlock_resync genlock_resync_chk #(.HW(HW), .VW(VW), .DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .gl_en      (gl_en_i),
    .line_dly   (line_dly_i),
    .armed      (armed),
    .h          (h_cnt_o),
    .v          (v_cnt_o),
    .h_total    (h_total_i),
    .v_total    (v_total_i),
    .field_even (field_even_o)
);

// File: tb/genlock_resync_test.sv
`timescale 1ns/1ps
module genlock_resync_test;
    localparam int HW = 11, VW = 11, DW = 8, AW = 4;
    localparam int HT = 19, VT = 9, LINE = HT + 1, FRAME = VT + 1;
    localparam int HSW = 3, VSW = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ext_vsync = 1'b1, gl_en = 1'b0, vonly = 1'b0, even_start = 1'b0;
    logic hs_tri = 1'b0, vs_tri = 1'b0;
    logic [DW-1:0] line_dly = '0;
    logic [AW-1:0] char_dly = '0, hs_adj = '0;
    logic [HW-1:0] h_cnt;
    logic [VW-1:0] v_cnt;
    logic field_even, hsync, hsync_oe, vsync, vsync_oe, dly_err;

    always #4 clk = ~clk;

    genlock_resync #(.HW(HW), .VW(VW), .DW(DW), .AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .ext_vsync_i(ext_vsync), .gl_en_i(gl_en),
        .line_dly_i(line_dly), .char_dly_i(char_dly), .hs_adj_i(hs_adj),
        .vonly_i(vonly), .even_start_i(even_start), .hs_tri_i(hs_tri),
        .vs_tri_i(vs_tri), .h_total_i(HW'(HT)), .v_total_i(VW'(VT)),
        .hs_width_i(HW'(HSW)), .vs_width_i(VW'(VSW)), .h_cnt_o(h_cnt),
        .v_cnt_o(v_cnt), .field_even_o(field_even), .hsync_o(hsync),
        .hsync_oe_o(hsync_oe), .vsync_o(vsync), .vsync_oe_o(vsync_oe),
        .dly_err_o(dly_err)
    );

    int checks = 0, errors = 0, cyc = 0;
    bit done = 1'b0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int    cyc;
        string tag;
        int    h;
        int    v;
        int    p;
    } exp_t;
    exp_t q[$];

    // free-running model, rebased at each expected resync
    int b_cyc = 0, b_h = 0, b_v = 0, b_p = 0;

    task automatic pred(input int c, output int h, output int v, output int p);
        int t, lines;
        t = b_h + (c - b_cyc);
        lines = b_v + t / LINE;
        h = t % LINE;
        v = lines % FRAME;
        p = b_p ^ ((lines / FRAME) % 2);
    endtask

    task automatic push_model(input int c, input string tag);
        exp_t e;
        e.cyc = c; e.tag = tag;
        pred(c, e.h, e.v, e.p);
        q.push_back(e);
    endtask

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // monitor: compare at the cycle each expected item names
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].cyc <= cyc) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (e.cyc != cyc || int'(h_cnt) != e.h || int'(v_cnt) != e.v || int'(field_even) != e.p) begin
                errors++;
                $display("FAIL %s cyc=%0d actual h=%0d v=%0d p=%0d expected h=%0d v=%0d p=%0d",
                         e.tag, e.cyc, h_cnt, v_cnt, field_even, e.h, e.v, e.p);
            end
        end
    end

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    // driver: one reference drop, expected results pushed to the queue
    task automatic do_sync(input string tag, input int d, input int c, input int adj,
                           input bit vo, input bit pre, input bit fires);
        int cur, f, h0;
        int ph, pv, pp;
        @(negedge clk);
        line_dly = DW'(d); char_dly = AW'(c); hs_adj = AW'(adj);
        vonly = vo; even_start = pre;
        ext_vsync = 1'b0;
        cur = cyc;
        f = cur + 1 + 3 + d * LINE + c;
        push_model(f - 1, {tag, " before"});
        if (fires) begin
            exp_t e;
            pred(f, ph, pv, pp);
            h0 = vo ? ph : adj;
            e.cyc = f; e.tag = {tag, " resync"}; e.h = h0; e.v = 0; e.p = pre;
            q.push_back(e);
            b_cyc = f; b_h = h0; b_v = 0; b_p = pre;
        end else begin
            push_model(f, {tag, " no resync"});
        end
        push_model(f + 37, {tag, " after"});
        repeat (6) @(negedge clk);
        ext_vsync = 1'b1;
        wait_until(f + 40);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int cur;
        repeat (4) @(negedge clk);
        // R9: reset state
        check("R9 reset h", int'(h_cnt), 0);
        check("R9 reset v", int'(v_cnt), 0);
        check("R9 reset field", int'(field_even), 0);
        check("R3 err off", int'(dly_err), 0);
        rst_n = 1'b1;
        b_cyc = cyc; b_h = 0; b_v = 0; b_p = 0;
        // R9 free-running wrap, R6 toggle at frame end
        push_model(b_cyc + 45, "R9 free run");
        push_model(b_cyc + 205, "R6 frame toggle");
        wait_until(b_cyc + 210);

        // R10 sync pulses and R7 enables
        for (int i = 0; i < 25; i++) begin
            @(negedge clk);
            check("R10 hsync", int'(hsync), int'(int'(h_cnt) < HSW));
            check("R10 vsync", int'(vsync), int'(int'(v_cnt) < VSW));
        end
        check("R7 hs oe on", int'(hsync_oe), 1);
        check("R7 vs oe on", int'(vsync_oe), 1);
        hs_tri = 1'b1;
        #1 check("R7 hs oe off", int'(hsync_oe), 0);
        check("R7 vs oe kept", int'(vsync_oe), 1);
        vs_tri = 1'b1; hs_tri = 1'b0;
        #1 check("R7 vs oe off", int'(vsync_oe), 0);
        check("R7 hs oe back", int'(hsync_oe), 1);

        // R1: disabled genlock ignores the reference
        gl_en = 1'b0;
        do_sync("R1 disabled", 2, 3, 4, 1'b0, 1'b1, 1'b0);

        // R3: zero delay flagged and no resync
        gl_en = 1'b1;
        line_dly = '0;
        #1 check("R3 err flag", int'(dly_err), 1);
        do_sync("R3 zero delay", 0, 2, 4, 1'b0, 1'b1, 1'b0);
        line_dly = 8'd2;
        #1 check("R3 err clear", int'(dly_err), 0);

        // R2/R4/R6: full resync, even field preset
        do_sync("R2 R4 full", 2, 3, 4, 1'b0, 1'b1, 1'b1);
        // R5/R6: vertical-only resync, odd field preset
        do_sync("R5 vonly", 3, 5, 7, 1'b1, 1'b0, 1'b1);
        // R2: minimum legal delay, no char delay
        do_sync("R2 min", 1, 0, 0, 1'b0, 1'b0, 1'b1);

        // R8: second edge restarts the countdown
        begin
            int f0, f1, ph, pv, pp;
            exp_t e;
            @(negedge clk);
            line_dly = 8'd2; char_dly = 4'd1; hs_adj = 4'd6; vonly = 1'b0; even_start = 1'b1;
            ext_vsync = 1'b0;
            cur = cyc;
            f0 = cur + 4 + 2 * LINE + 1;
            repeat (4) @(negedge clk);
            ext_vsync = 1'b1;
            wait_until(cur + 10);
            ext_vsync = 1'b0;
            f1 = cur + 10 + 4 + 2 * LINE + 1;
            push_model(f0, "R8 first edge dropped");
            push_model(f1 - 1, "R8 before");
            pred(f1, ph, pv, pp);
            e.cyc = f1; e.tag = "R8 restart resync"; e.h = 6; e.v = 0; e.p = 1;
            q.push_back(e);
            b_cyc = f1; b_h = 6; b_v = 0; b_p = 1;
            push_model(f1 + 37, "R8 after");
            repeat (6) @(negedge clk);
            ext_vsync = 1'b1;
            wait_until(f1 + 40);
        end

        wait_until(cyc + 2);
        check("queue drained", q.size(), 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule